// File: doc/BRIEF.md
# XOR-Hashed DRAM Address Decoder

This block turns a 64-bit physical address into DRAM coordinates: channel, rank, bank group, bank, row, column and byte offset. Every coordinate bit is taken from an address position chosen by configuration. A coordinate bit may instead be hashed. In that case the address bit at its position is replaced by the parity of a configured set of address bits before any field is extracted. A memory controller front end loads the configuration through a small write port. It then streams addresses into the block, one per cycle, and reads the registered coordinates one cycle later. A second copy of the channel value is driven on its own port, so routing logic can pick it up without fanning out from the full field bundle.

Each field holds up to 24 entries, and each entry lists up to 8 address indices together with a count. Pseudo-channel entries are stacked directly above the configured rank entries and come out as extra rank bits. Checking that a configuration is sensible is left to the software that writes it.

Top module: `dram_xhash_decoder`

## Requirements
- R1: After reset `outValid` is low and every entry is empty, so a decode returns zero in every field.
- R2: Entry i of a field drives bit i of that field, least significant first. An entry with count 1 copies the address bit at its first index.
- R3: An entry with count n from 2 to 8 yields the parity of the address bits at its first n indices. An entry with count 0 makes its field bit read as zero.
- R4: A hashed entry replaces the address bit at its first index before extraction. Every entry whose first index names that position reads the hashed value, whichever field that entry belongs to.
- R5: Every parity input is taken from the incoming address as presented, never from a bit that another hash has replaced.
- R6: Pseudo-channel entries are placed above the rank entries. Pseudo entry j lands on rank bit (r + j), where r is the number of non-empty rank entries. Bits above rank width 24 are dropped.
- R7: An address accepted at a clock edge (`inValid` and `inReady` both high) gives `outValid` high with its fields after that same edge. In every other case `outValid` is low in the next cycle and the fields hold their value.
- R8: `inReady` is low in every cycle in which `cfgWrEn` is high, so an address offered in such a cycle is not decoded.
- R9: `chanRoute` equals `chanOut` whenever `outValid` is high.
- R10: A configuration write selects a field by code: 0 channel, 1 rank, 2 pseudo-channel, 3 bank group, 4 bank, 5 row, 6 column, 7 byte. `cfgEntry` selects the entry and `cfgCount` gives the count. Index k of the list sits in `cfgIdx[6k+5:6k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgField | input | 3 | Field code of the written entry |
| cfgEntry | input | 5 | Entry number within the field |
| cfgCount | input | 4 | Number of valid indices (0 empty, 1 plain, 2..8 hashed) |
| cfgIdx | input | 48 | Eight packed 6-bit address indices |
| inValid | input | 1 | Address offered |
| inReady | output | 1 | Block can accept an address this cycle |
| addrIn | input | 64 | Physical address |
| outValid | output | 1 | Decoded fields valid |
| chanOut | output | 24 | Channel field |
| rankOut | output | 24 | Rank field with pseudo-channel bits stacked above |
| bankGroupOut | output | 24 | Bank group field |
| bankOut | output | 24 | Bank field |
| rowOut | output | 24 | Row field |
| colOut | output | 24 | Column field |
| byteOut | output | 24 | Byte offset field |
| chanRoute | output | 24 | Separate copy of the channel field for routing |

## Verification
A configuration write and an address offer can arrive in the same cycle. The bench provokes this by raising `cfgWrEn` and `inValid` together. It then judges the outcome at the ports: `inReady` must be low during that cycle, `outValid` must stay low after the edge, and the fields must keep the previous result. Within the datapath, one hash can rewrite a bit that a second hash also reads. The bench sets up a channel hash that rewrites the row bit while the bank hash still reads it. It then sweeps walking-one, walking-zero and random addresses against an arithmetic model of the parity rules.

// File: rtl/dram_xhash_pkg.sv
package dram_xhash_pkg;

  localparam int NUM_FIELDS = 8;
  localparam int STB_ENT_W  = 8;

  // Field codes; the write port decodes these values
  typedef enum logic [2:0] {
    FLD_CHAN   = 3'd0,
    FLD_RANK   = 3'd1,
    FLD_PSEUDO = 3'd2,
    FLD_BGRP   = 3'd3,
    FLD_BANK   = 3'd4,
    FLD_ROW    = 3'd5,
    FLD_COL    = 3'd6,
    FLD_BYTE   = 3'd7
  } fieldSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 cfgWrite;
    logic                 capture;
    logic [2:0]           field;
    logic [STB_ENT_W-1:0] entry;
  } ctrlStrobe_t;

endpackage

// File: rtl/dram_xhash_ctrl.sv
module dram_xhash_ctrl
  import dram_xhash_pkg::*;
#(
  parameter int ENT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [2:0]       cfgField,
  input  logic [ENT_W-1:0] cfgEntry,
  input  logic             inValid,
  output logic             inReady,
  output logic             outValid,
  output ctrlStrobe_t      strb
);

  logic accept;

  // A configuration write owns the cycle; no address is taken alongside it
  assign inReady = ~cfgWrEn;
  assign accept  = inValid & inReady;

  always_comb begin
    strb          = '0;
    strb.cfgWrite = cfgWrEn;
    strb.capture  = accept;
    strb.field    = cfgField;
    strb.entry    = STB_ENT_W'(cfgEntry);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= accept;
  end

endmodule

// File: rtl/dram_xhash_datapath.sv
module dram_xhash_datapath
  import dram_xhash_pkg::*;
#(
  parameter int AW = 64,
  parameter int NE = 24,
  parameter int NX = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strb,
  input  logic [$clog2(NX+1)-1:0]  cfgCount,
  input  logic [NX*$clog2(AW)-1:0] cfgIdx,
  input  logic [AW-1:0]            addrIn,
  output logic [NE-1:0]            chanOut,
  output logic [NE-1:0]            rankOut,
  output logic [NE-1:0]            bankGroupOut,
  output logic [NE-1:0]            bankOut,
  output logic [NE-1:0]            rowOut,
  output logic [NE-1:0]            colOut,
  output logic [NE-1:0]            byteOut,
  output logic [NE-1:0]            chanRoute
);

  localparam int IDX_W = $clog2(AW);
  localparam int CNT_W = $clog2(NX+1);
  localparam int ENT_W = $clog2(NE);
  localparam int LEN_W = $clog2(NE+1);

  logic [CNT_W-1:0] cnt [NUM_FIELDS][NE];
  logic [IDX_W-1:0] idx [NUM_FIELDS][NE][NX];

  logic [AW-1:0]    repMask;
  logic [AW-1:0]    repVal;
  logic [AW-1:0]    hashedAddr;
  logic [NE-1:0]    rawField [NUM_FIELDS];
  logic [NE-1:0]    usedMask [NUM_FIELDS];
  logic [LEN_W-1:0] rankLen;
  logic [NE-1:0]    rankMerged;
  logic             entryOk;

  assign entryOk = strb.cfgWrite && (int'(strb.entry) < NE);

  // Entry counts: reset to empty
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int f = 0; f < NUM_FIELDS; f++)
        for (int e = 0; e < NE; e++)
          cnt[f][e] <= '0;
    end else if (entryOk) begin
      cnt[strb.field][strb.entry[ENT_W-1:0]] <= cfgCount;
    end
  end

  // Index lists: meaningful only under a non-zero count, so no reset
  always_ff @(posedge clk) begin
    if (entryOk) begin
      for (int k = 0; k < NX; k++)
        idx[strb.field][strb.entry[ENT_W-1:0]][k] <= cfgIdx[k*IDX_W +: IDX_W];
    end
  end

  // Parity of every hashed entry, all read from the untouched input address
  always_comb begin
    repMask = '0;
    repVal  = '0;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      for (int e = 0; e < NE; e++) begin
        logic par;
        par = 1'b0;
        for (int k = 0; k < NX; k++)
          if (CNT_W'(k) < cnt[f][e]) par = par ^ addrIn[idx[f][e][k]];
        if (cnt[f][e] > CNT_W'(1)) begin
          repMask[idx[f][e][0]] = 1'b1;
          repVal[idx[f][e][0]]  = par;
        end
      end
    end
  end

  assign hashedAddr = (addrIn & ~repMask) | repVal;

  // Per-field bit extraction from the hashed address
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    logic [NE-1:0] fieldBits;
    logic [NE-1:0] fieldUsed;
    always_comb begin
      for (int e = 0; e < NE; e++) begin
        fieldUsed[e] = (cnt[f][e] != '0);
        fieldBits[e] = fieldUsed[e] & hashedAddr[idx[f][e][0]];
      end
    end
    assign rawField[f] = fieldBits;
    assign usedMask[f] = fieldUsed;
  end

  // Pseudo-channel bits stacked above the configured rank bits
  assign rankLen    = LEN_W'($countones(usedMask[int'(FLD_RANK)]));
  assign rankMerged = rawField[int'(FLD_RANK)] | (rawField[int'(FLD_PSEUDO)] << rankLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanOut      <= '0;
      rankOut      <= '0;
      bankGroupOut <= '0;
      bankOut      <= '0;
      rowOut       <= '0;
      colOut       <= '0;
      byteOut      <= '0;
      chanRoute    <= '0;
    end else if (strb.capture) begin
      chanOut      <= rawField[int'(FLD_CHAN)];
      rankOut      <= rankMerged;
      bankGroupOut <= rawField[int'(FLD_BGRP)];
      bankOut      <= rawField[int'(FLD_BANK)];
      rowOut       <= rawField[int'(FLD_ROW)];
      colOut       <= rawField[int'(FLD_COL)];
      byteOut      <= rawField[int'(FLD_BYTE)];
      chanRoute    <= rawField[int'(FLD_CHAN)];
    end
  end

endmodule

// File: rtl/dram_xhash_decoder.sv
module dram_xhash_decoder
  import dram_xhash_pkg::*;
#(
  parameter int AW = 64,
  parameter int NE = 24,
  parameter int NX = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWrEn,
  input  logic [2:0]               cfgField,
  input  logic [$clog2(NE)-1:0]    cfgEntry,
  input  logic [$clog2(NX+1)-1:0]  cfgCount,
  input  logic [NX*$clog2(AW)-1:0] cfgIdx,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [AW-1:0]            addrIn,
  output logic                     outValid,
  output logic [NE-1:0]            chanOut,
  output logic [NE-1:0]            rankOut,
  output logic [NE-1:0]            bankGroupOut,
  output logic [NE-1:0]            bankOut,
  output logic [NE-1:0]            rowOut,
  output logic [NE-1:0]            colOut,
  output logic [NE-1:0]            byteOut,
  output logic [NE-1:0]            chanRoute
);

  localparam int ENT_W = $clog2(NE);

  ctrlStrobe_t strb;

  dram_xhash_ctrl #(.ENT_W(ENT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgField (cfgField),
    .cfgEntry (cfgEntry),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .strb     (strb)
  );

  dram_xhash_datapath #(.AW(AW), .NE(NE), .NX(NX)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cfgCount     (cfgCount),
    .cfgIdx       (cfgIdx),
    .addrIn       (addrIn),
    .chanOut      (chanOut),
    .rankOut      (rankOut),
    .bankGroupOut (bankGroupOut),
    .bankOut      (bankOut),
    .rowOut       (rowOut),
    .colOut       (colOut),
    .byteOut      (byteOut),
    .chanRoute    (chanRoute)
  );

endmodule

// File: rtl/dram_xhash_checker.sv
module dram_xhash_checker #(
  parameter int NE = 24
) (
  input logic          clk,
  input logic          rstN,
  input logic          cfgWrEn,
  input logic          inValid,
  input logic          inReady,
  input logic          outValid,
  input logic [NE-1:0] rowOut,
  input logic [NE-1:0] bankOut,
  input logic [NE-1:0] rankOut
);

  a_r7_valid_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  a_r7_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> !outValid);

  a_r7_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> ($stable(rowOut) && $stable(bankOut) && $stable(rankOut)));

  a_r8_ready_low_on_cfg: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |-> !inReady);

  a_r8_cfg_blocks_valid: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> !outValid);

endmodule

bind dram_xhash_decoder dram_xhash_checker #(.NE(NE)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgWrEn  (cfgWrEn),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .rowOut   (rowOut),
  .bankOut  (bankOut),
  .rankOut  (rankOut)
);

// File: tb/dram_xhash_decoder_tb.sv
module dram_xhash_decoder_tb;

  localparam int AW = 64;
  localparam int NE = 24;
  localparam int NX = 8;
  localparam int FW = 7 * NE;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [2:0]    cfgField = '0;
  logic [4:0]    cfgEntry = '0;
  logic [3:0]    cfgCount = '0;
  logic [47:0]   cfgIdx = '0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [AW-1:0] addrIn = '0;
  logic          outValid;
  logic [NE-1:0] chanOut, rankOut, bankGroupOut, bankOut, rowOut, colOut, byteOut, chanRoute;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench-side configuration model
  int mCnt [8][NE];
  int mIdx [8][NE][NX];
  logic [FW-1:0] expVec;

  always #2.5 clk = ~clk;

  dram_xhash_decoder #(.AW(AW), .NE(NE), .NX(NX)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgField(cfgField),
    .cfgEntry(cfgEntry), .cfgCount(cfgCount), .cfgIdx(cfgIdx),
    .inValid(inValid), .inReady(inReady), .addrIn(addrIn),
    .outValid(outValid), .chanOut(chanOut), .rankOut(rankOut),
    .bankGroupOut(bankGroupOut), .bankOut(bankOut), .rowOut(rowOut),
    .colOut(colOut), .byteOut(byteOut), .chanRoute(chanRoute)
  );

  function automatic logic [FW-1:0] gotVec();
    return {chanOut, rankOut, bankGroupOut, bankOut, rowOut, colOut, byteOut};
  endfunction

  task automatic check(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected fields from the rules of R2..R6 (field codes per R10)
  task automatic computeExp(input logic [AW-1:0] a);
    logic [AW-1:0] h;
    logic [NE-1:0] raw [8];
    logic [NE-1:0] rk;
    int rl;
    h = a;
    for (int f = 0; f < 8; f++)
      for (int e = 0; e < NE; e++)
        if (mCnt[f][e] >= 2) begin
          logic p;
          p = 1'b0;
          for (int k = 0; k < mCnt[f][e]; k++) p = p ^ a[mIdx[f][e][k]];
          h[mIdx[f][e][0]] = p;
        end
    rl = 0;
    for (int f = 0; f < 8; f++)
      for (int e = 0; e < NE; e++) begin
        raw[f][e] = (mCnt[f][e] > 0) ? h[mIdx[f][e][0]] : 1'b0;
        if (f == 1 && mCnt[f][e] > 0) rl++;
      end
    rk = raw[1];
    for (int j = 0; j < NE; j++)
      if (raw[2][j] && (rl + j) < NE) rk[rl + j] = 1'b1;
    expVec = {raw[0], rk, raw[3], raw[4], raw[5], raw[6], raw[7]};
  endtask

  task automatic setEntry(input int f, input int e, input int n,
                          input int i0 = 0, input int i1 = 0, input int i2 = 0, input int i3 = 0,
                          input int i4 = 0, input int i5 = 0, input int i6 = 0, input int i7 = 0);
    int l [8];
    l = '{i0, i1, i2, i3, i4, i5, i6, i7};
    mCnt[f][e] = n;
    @(negedge clk);
    cfgWrEn  = 1'b1;
    cfgField = 3'(f);
    cfgEntry = 5'(e);
    cfgCount = 4'(n);
    for (int k = 0; k < 8; k++) begin
      mIdx[f][e][k] = l[k];
      cfgIdx[k*6 +: 6] = 6'(l[k]);
    end
    #1;
    check("R8 ready low on cfg write", {{(FW-1){1'b0}}, inReady}, '0);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic decodeOne(input string req, input logic [AW-1:0] a);
    @(negedge clk);
    inValid = 1'b1;
    addrIn  = a;
    @(negedge clk);
    inValid = 1'b0;
    computeExp(a);
    check({req, " (R7 valid)"}, {{(FW-1){1'b0}}, outValid}, {{(FW-1){1'b0}}, 1'b1});
    check(req, gotVec(), expVec);
    check("R9 route copy", {{(FW-NE){1'b0}}, chanRoute}, {{(FW-NE){1'b0}}, chanOut});
  endtask

  task automatic sweep(input string req, input int nRand);
    for (int b = 0; b < AW; b++) decodeOne(req, AW'(1) << b);
    for (int b = 0; b < AW; b++) decodeOne(req, ~(AW'(1) << b));
    for (int r = 0; r < nRand; r++) decodeOne(req, {$urandom, $urandom});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] held;
    for (int f = 0; f < 8; f++)
      for (int e = 0; e < NE; e++) begin
        mCnt[f][e] = 0;
        for (int k = 0; k < NX; k++) mIdx[f][e][k] = 0;
      end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset valid", {{(FW-1){1'b0}}, outValid}, '0);
    check("R1 reset fields", gotVec(), '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 ready after reset", {{(FW-1){1'b0}}, inReady}, {{(FW-1){1'b0}}, 1'b1});
    decodeOne("R1 empty config", 64'hFFFF_FFFF_FFFF_FFFF);

    // Example mapping: R2 plain entries, R3 two-input hash on bank bit 0
    setEntry(7, 0, 1, 0);
    setEntry(7, 1, 1, 1);
    for (int i = 0; i < 11; i++) setEntry(6, i, 1, 2 + i);
    setEntry(4, 0, 2, 13, 16);
    setEntry(4, 1, 1, 14);
    setEntry(4, 2, 1, 15);
    setEntry(5, 0, 1, 16);
    for (int i = 0; i < 16; i++) setEntry(3, i, 1, 17 + i);
    setEntry(1, 0, 1, 33);
    decodeOne("R3 bank hash 13^16", 64'h0000_0000_0001_0000);
    decodeOne("R3 bank hash cancels", 64'h0000_0000_0001_2000);
    sweep("R2 example map", 60);

    // R7: idle cycle keeps valid low and fields held
    held = gotVec();
    @(negedge clk);
    check("R7 idle valid low", {{(FW-1){1'b0}}, outValid}, '0);
    check("R7 fields held", gotVec(), held);

    // R8: cfg write together with an address offer
    @(negedge clk);
    cfgWrEn = 1'b1; cfgField = 3'd1; cfgEntry = 5'd0; cfgCount = 4'd1;
    cfgIdx = 48'd33;
    inValid = 1'b1; addrIn = 64'h1234_5678_9ABC_DEF0;
    @(negedge clk);
    cfgWrEn = 1'b0; inValid = 1'b0;
    check("R8 offer during cfg not decoded", {{(FW-1){1'b0}}, outValid}, '0);
    check("R8 fields unchanged", gotVec(), held);

    // R6 pseudo stacking; R3 wide hashes; R4/R5 hash rewriting a bit another hash reads
    setEntry(2, 0, 1, 34);
    setEntry(2, 1, 1, 35);
    setEntry(0, 0, 5, 40, 41, 42, 43, 44);
    setEntry(0, 1, 3, 16, 13, 45);
    setEntry(0, 2, 1, 47);
    setEntry(0, 3, 8, 50, 51, 52, 53, 54, 55, 56, 57);
    decodeOne("R6 pseudo above rank", 64'h0000_0004_0000_0000);
    decodeOne("R4 row sees channel hash", 64'h0000_2000_0000_2000);
    decodeOne("R5 bank hash reads original", 64'h0000_0000_0001_0000);
    sweep("R4 R5 R6 overlapping hashes", 60);

    // R3: emptying an entry zeroes its bit; R6 with two rank bits
    setEntry(3, 15, 0);
    setEntry(1, 1, 1, 36);
    decodeOne("R3 empty entry reads zero", 64'hFFFF_FFFF_FFFF_FFFF);
    sweep("R6 two rank bits", 40);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule